// File: doc/BRIEF.md
# Pulse-Driven Numeric Panel Driver

This block drives a four-digit decimal maintenance panel whose only inputs are a clear strobe and an increment strobe. A request gives a binary code and a base offset. The block adds the two numbers. It fires one clear strobe, then fires one increment strobe for each unit of the sum, so the panel ends up showing the sum.

Strobes are spaced by a programmable number of clock cycles. The panel is slow and can miss pulses that arrive too close together. A short spacing is used normally. A longer spacing can be chosen for each request. Sums that the four digits cannot show are limited to 9999, and a sticky flag records that this happened.

A small model of the panel is part of the block: a four-digit BCD counter fed by the two strobes. Its digits come out on a port, so the result can be observed directly.

Top module: `pnl_pulse_drv`

## Requirements
- R1: After a synchronous reset, busy_o, done_o, clr_o, inc_o and ovf_o are 0 and disp_o reads 0000.
- R2: A start_i sampled while busy_o is low is accepted. In the next cycle busy_o is 1 and clr_o is high. clr_o stays high for exactly one cycle, and an operation contains exactly one clear strobe.
- R3: The number of inc_o pulses equals value_i + ofs_i, both latched at the accepted start. disp_o then holds that number in BCD: digit 0, the least significant, is in bits 3:0, digit 1 in bits 7:4, and so on.
- R4: With long_gap_i = 0 at the accepted start, the spacing from the clear strobe to the first increment, and between consecutive increments, is GAP_SHORT cycles (default 15). With long_gap_i = 1 the spacing is GAP_LONG cycles (default 23).
- R5: A sum above 9999 produces exactly 9999 increments and sets ovf_o. ovf_o stays 1 across later operations until reset.
- R6: done_o is a one-cycle pulse that comes one cycle after the last strobe. busy_o stays high from acceptance until that cycle and is low while done_o is high.
- R7: A sum of zero produces only the clear strobe. done_o follows one cycle after it.
- R8: A start_i asserted while busy_o is high is ignored. The running operation finishes with its own count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe |
| value_i | input | VAL_W | Code to display |
| ofs_i | input | VAL_W | Base offset added to the code |
| long_gap_i | input | 1 | Selects the long strobe spacing |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| clr_o | output | 1 | Panel clear strobe |
| inc_o | output | 1 | Panel increment strobe |
| ovf_o | output | 1 | Sticky limit flag |
| disp_o | output | 4*DIGITS | BCD digits of the panel model |

## Verification
Let the clock edge that accepts a start be cycle 0. All timing is then fixed:
- The clear strobe is visible in cycle 0's output interval.
- Increment k appears k*G cycles after the clear, where G is the chosen spacing.
- done_o appears at N*G+1 cycles after the clear, for a sum of N.
- The panel digits already show the final value in that done cycle.

The bench samples only on falling edges and counts falling edges from the clear strobe. It checks each increment at exactly the expected offset from the previous strobe, and checks done_o, busy_o and disp_o at the computed done cycle.

// File: rtl/pnl_pkg.sv
package pnl_pkg;
  localparam int BCD_W = 4;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_st_t;
endpackage

// File: rtl/pnl_sum_clamp.sv
module pnl_sum_clamp #(
  parameter int VAL_W = 14,
  parameter int MAX   = 9999
) (
  input  logic [VAL_W-1:0] value_i,
  input  logic [VAL_W-1:0] ofs_i,
  output logic [VAL_W-1:0] cnt_o,
  output logic             over_o
);
  localparam logic [VAL_W:0] MAX_W = (VAL_W+1)'(MAX);

  logic [VAL_W:0] sum;

  always_comb begin
    sum    = {1'b0, value_i} + {1'b0, ofs_i};
    over_o = (sum > MAX_W);
    cnt_o  = over_o ? MAX_W[VAL_W-1:0] : sum[VAL_W-1:0];
  end
endmodule

// File: rtl/pnl_seq.sv
module pnl_seq
  import pnl_pkg::*;
#(
  parameter int CNT_W     = 14,
  parameter int GAP_W     = 5,
  parameter int GAP_SHORT = 15,
  parameter int GAP_LONG  = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             long_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             clr_o,
  output logic             inc_o
);
  localparam logic [GAP_W-1:0] RLD_S = GAP_W'(GAP_SHORT - 1);
  localparam logic [GAP_W-1:0] RLD_L = GAP_W'(GAP_LONG - 1);

  seq_st_t          st;
  logic [CNT_W-1:0] rem;
  logic [GAP_W-1:0] tmr;
  logic             lg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      busy_o <= 1'b0;
      done_o <= 1'b0;
      clr_o  <= 1'b0;
      inc_o  <= 1'b0;
      rem    <= '0;
      tmr    <= '0;
      lg_q   <= 1'b0;
    end else begin
      clr_o  <= 1'b0;
      inc_o  <= 1'b0;
      done_o <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_i) begin
            st     <= ST_RUN;
            busy_o <= 1'b1;
            clr_o  <= 1'b1;
            rem    <= cnt_i;
            lg_q   <= long_i;
            tmr    <= long_i ? RLD_L : RLD_S;
          end
        end
        ST_RUN: begin
          if (rem == '0) begin
            st     <= ST_IDLE;
            busy_o <= 1'b0;
            done_o <= 1'b1;
          end else if (tmr == '0) begin
            inc_o <= 1'b1;
            rem   <= rem - 1'b1;
            tmr   <= lg_q ? RLD_L : RLD_S;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pnl_bcd_model.sv
module pnl_bcd_model
  import pnl_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr_i,
  input  logic                    inc_i,
  output logic [BCD_W*DIGITS-1:0] disp_o
);
  logic [DIGITS:0] cy;

  assign cy[0] = inc_i;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    logic [BCD_W-1:0] d;

    always_ff @(posedge clk) begin
      if (rst || clr_i) begin
        d <= '0;
      end else if (cy[i]) begin
        d <= (d == BCD_W'(9)) ? '0 : d + 1'b1;
      end
    end

    assign cy[i+1] = cy[i] && (d == BCD_W'(9));
    assign disp_o[BCD_W*i +: BCD_W] = d;
  end
endmodule

// File: rtl/pnl_pulse_drv.sv
module pnl_pulse_drv
  import pnl_pkg::*;
#(
  parameter int DIGITS    = 4,
  parameter int VAL_W     = 14,
  parameter int GAP_SHORT = 15,
  parameter int GAP_LONG  = 23
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [VAL_W-1:0]        value_i,
  input  logic [VAL_W-1:0]        ofs_i,
  input  logic                    long_gap_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    clr_o,
  output logic                    inc_o,
  output logic                    ovf_o,
  output logic [BCD_W*DIGITS-1:0] disp_o
);
  localparam int DISP_W = BCD_W * DIGITS;
  localparam int MAX    = (10 ** DIGITS) - 1;
  localparam int GAP_MX = (GAP_LONG > GAP_SHORT) ? GAP_LONG : GAP_SHORT;
  localparam int GAP_W  = $clog2(GAP_MX + 1);

  logic [VAL_W-1:0] cnt;
  logic             over;
  logic             accept;

  assign accept = start_i && !busy_o;

  pnl_sum_clamp #(.VAL_W(VAL_W), .MAX(MAX)) u_sum (
    .value_i (value_i),
    .ofs_i   (ofs_i),
    .cnt_o   (cnt),
    .over_o  (over)
  );

  pnl_seq #(
    .CNT_W(VAL_W), .GAP_W(GAP_W),
    .GAP_SHORT(GAP_SHORT), .GAP_LONG(GAP_LONG)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .cnt_i   (cnt),
    .long_i  (long_gap_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .clr_o   (clr_o),
    .inc_o   (inc_o)
  );

  always_ff @(posedge clk) begin
    if (rst) ovf_o <= 1'b0;
    else if (accept && over) ovf_o <= 1'b1;
  end

  pnl_bcd_model #(.DIGITS(DIGITS)) u_panel (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (clr_o),
    .inc_i  (inc_o),
    .disp_o (disp_o)
  );
endmodule

// File: rtl/pnl_pulse_drv_chk.sv
module pnl_pulse_drv_chk #(
  parameter int DISP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              clr_o,
  input logic              inc_o,
  input logic              ovf_o,
  input logic [DISP_W-1:0] disp_o
);
  // R2: accepted start yields the clear strobe and busy next cycle
  p_clr_after_start_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (clr_o && busy_o));

  // R2: clear and increment never coincide
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    !(clr_o && inc_o));

  // R4: increments only inside an operation
  p_inc_in_busy_r4: assert property (@(posedge clk) disable iff (rst)
    inc_o |-> busy_o);

  // R5: overflow flag is sticky
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o);

  // R6: done is a single-cycle pulse with busy low
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  // R3: panel digits move only on a strobe
  p_disp_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!clr_o && !inc_o) |=> $stable(disp_o));
endmodule

bind pnl_pulse_drv pnl_pulse_drv_chk #(.DISP_W(DISP_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .clr_o   (clr_o),
  .inc_o   (inc_o),
  .ovf_o   (ovf_o),
  .disp_o  (disp_o)
);

// File: tb/pnl_pulse_drv_test.sv
module pnl_pulse_drv_test;
  localparam int DIGITS = 4;
  localparam int VAL_W  = 14;
  localparam int GS     = 4;
  localparam int GL     = 6;
  localparam int NVEC   = 6;
  // entry: {value, offset, long_gap}
  localparam logic [28:0] VEC [NVEC] = '{
    {14'd5,  14'd0,  1'b0},
    {14'd7,  14'd3,  1'b1},
    {14'd0,  14'd0,  1'b0},
    {14'd12, 14'd30, 1'b1},
    {14'd1,  14'd0,  1'b1},
    {14'd98, 14'd2,  1'b0}
  };

  logic clk = 1'b0;
  logic rst, start_i, long_gap_i;
  logic [VAL_W-1:0] value_i, ofs_i;
  logic busy_o, done_o, clr_o, inc_o, ovf_o;
  logic [4*DIGITS-1:0] disp_o;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  ovf_exp = 1'b0;
  bit  ended   = 1'b0;

  always #2 clk = ~clk;

  pnl_pulse_drv #(.DIGITS(DIGITS), .VAL_W(VAL_W), .GAP_SHORT(GS), .GAP_LONG(GL)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .value_i(value_i), .ofs_i(ofs_i),
    .long_gap_i(long_gap_i), .busy_o(busy_o), .done_o(done_o), .clr_o(clr_o),
    .inc_o(inc_o), .ovf_o(ovf_o), .disp_o(disp_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int to_bcd(input int v);
    int r = 0;
    for (int i = 0; i < DIGITS; i++) begin
      r = r | ((v % 10) << (4 * i));
      v = v / 10;
    end
    return r;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    ovf_exp = 1'b0;
    @(negedge clk);
    chk(!busy_o && !done_o && !clr_o && !inc_o, "R1 ctl", {busy_o, done_o, clr_o, inc_o}, 0);
    chk(!ovf_o, "R1 ovf", ovf_o, 0);
    chk(disp_o == '0, "R1 disp", disp_o, 0);
  endtask

  task automatic run_op(input int v, input int o, input bit lg, input bit poke);
    int  sum  = v + o;
    int  expn = (sum > 9999) ? 9999 : sum;
    int  gap  = lg ? GL : GS;
    int  cyc  = 0;
    int  last = 0;
    int  nclr = 0;
    int  ninc = 0;
    bit  fin  = 1'b0;
    bit  gap_ok = 1'b1;
    bit  busy_ok = 1'b1;
    if (sum > 9999) ovf_exp = 1'b1;
    @(negedge clk);
    start_i = 1'b1; value_i = VAL_W'(v); ofs_i = VAL_W'(o); long_gap_i = lg;
    @(negedge clk);
    start_i = 1'b0; long_gap_i = ~lg; value_i = '1; ofs_i = '1;
    chk(clr_o && busy_o, "R2 clear after start", {clr_o, busy_o}, 3);
    while (!fin && cyc < 60000) begin
      @(negedge clk);
      cyc++;
      start_i = 1'b0;
      if (poke && cyc == 2) begin
        start_i = 1'b1; value_i = VAL_W'(50); ofs_i = '0;  // R8 stray request
      end
      if (clr_o) nclr++;
      if (inc_o) begin
        ninc++;
        if (cyc - last != gap && gap_ok) begin
          gap_ok = 1'b0;
          chk(1'b0, "R4 spacing", cyc - last, gap);
        end
        last = cyc;
      end
      if (done_o) fin = 1'b1;
      else if (!busy_o) busy_ok = 1'b0;
    end
    start_i = 1'b0;
    chk(gap_ok, "R4 spacing ok", gap_ok, 1);
    chk(nclr == 0, "R2 single clear", nclr + 1, 1);
    chk(busy_ok, "R6 busy held", busy_ok, 1);
    chk(cyc == expn * gap + 1, (expn == 0) ? "R7 done after clear" : "R6 done timing",
        cyc, expn * gap + 1);
    chk(!busy_o, "R6 busy low at done", busy_o, 0);
    chk(ninc == expn, poke ? "R8 count kept" : "R3 pulse count", ninc, expn);
    chk(disp_o == to_bcd(expn), "R3 display", disp_o, to_bcd(expn));
    chk(ovf_o == ovf_exp, "R5 overflow flag", ovf_o, ovf_exp);
    @(negedge clk);
    chk(!done_o, "R6 done one cycle", done_o, 0);
  endtask

  initial begin
    rst = 1'b1; start_i = 1'b0; long_gap_i = 1'b0; value_i = '0; ofs_i = '0;
    do_reset();
    for (int k = 0; k < NVEC; k++)
      run_op(int'(VEC[k][28:15]), int'(VEC[k][14:1]), VEC[k][0], 1'b0);
    // R8: request during busy is ignored
    run_op(9, 0, 1'b0, 1'b1);
    // R5: clamp at 9999, then flag persists
    run_op(9990, 20, 1'b0, 1'b0);
    run_op(3, 0, 1'b0, 1'b0);
    chk(ovf_o, "R5 sticky", ovf_o, 1);
    // R1: reset clears flag and panel
    do_reset();
    ended = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!ended) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule